// File: doc/BRIEF.md
# Packed Round-to-Integral Unit

This block takes a 64-bit word that holds several floating-point numbers side by side. It rounds each number to the nearest whole value and keeps the result in the same floating-point format. A two-bit size code picks the layout: four half-precision lanes or two single-precision lanes. The rounding mode is fixed to round-to-nearest with ties to even, and no control input can change it. No inexact indication is produced. Zeros and infinities keep their sign. NaNs are quieted, or replaced by the default quiet NaN when the default-NaN control is set. Subnormal inputs are flushed to a zero of the same sign. An unsupported size code gives an undefined flag and an all-zero data word instead of a result.

Operands enter on a valid/ready stream and results leave on a second valid/ready stream. There is one register stage between the two streams.

The input side takes an operand when `in_valid` and `in_ready` are both high on a rising edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result, its flag and `out_valid` stay frozen and no new operand is taken. A result is presented in the cycle after its operand was accepted. The control pins `half_en` and `dnan_en` are sampled together with the operand.

Top module: `rint_packed`

## Requirements
- R1: With size code 01 and `half_en` high, the word is treated as four binary16 lanes. Lane i occupies bits [16i+15:16i] of both the input and the output.
- R2: Size code 10 treats the word as two binary32 lanes, with lane i in bits [32i+31:32i]. This holds whatever the value of `half_en`.
- R3: Size codes 00 and 11, and code 01 while `half_en` is low, set `out_undef`. In those cases the output data is all zeros.
- R4: A value exactly halfway between two integers rounds to the even one (2.5→2.0, 3.5→4.0, -1.5→-2.0). Other values round to the nearest integer.
- R5: A magnitude below 0.5, and exactly 0.5, gives zero with the input's sign. A magnitude above 0.5 and below 1.0 gives 1.0 with the input's sign.
- R6: A lane whose unbiased exponent is at least the fraction width (10 for binary16, 23 for binary32) passes unchanged. When rounding carries out of the fraction, the exponent rises by one and the fraction becomes zero.
- R7: A zero or infinite input comes out unchanged, sign included. A subnormal input comes out as zero with its sign.
- R8: A NaN input with `dnan_en` low keeps its sign and payload and has its top fraction bit set. With `dnan_en` high, every NaN lane becomes the positive default quiet NaN: exponent all ones, top fraction bit one, all other bits zero.
- R9: An operand is accepted when `in_valid` and `in_ready` are both high. Its result appears with `out_valid` high in the next cycle. While `out_valid` is high and `out_ready` is low, `in_ready` is low and the output stays unchanged.
- R10: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| half_en | input | 1 | Allows the half-precision size code |
| dnan_en | input | 1 | Replaces every NaN with the default quiet NaN |
| in_valid | input | 1 | An operand is offered |
| in_ready | output | 1 | The block can take an operand |
| in_size | input | 2 | Lane size code (01 half, 10 single) |
| in_data | input | 64 | Packed operand |
| out_valid | output | 1 | A result is held |
| out_ready | input | 1 | The consumer takes the result |
| out_data | output | 64 | Packed rounded result |
| out_undef | output | 1 | The operand's size code was not supported |

## Verification
The bench goes after exact ties on both sides of an even integer, and after values whose rounding carries into the exponent (1023.5, 1.5, 3.5). A design that rounded ties away from zero, or dropped the carry, would return 3.0, 1.0 or a value with the exponent left unchanged. It checks exactly 0.5 and values just above and below it, where a wrong boundary would give 1.0 for 0.5 or zero for 0.75. It also feeds negative values, where a lost sign bit would turn -0.5 into +0.0. The NaN paths are run in both default-NaN settings, catching a design that kept a signalling NaN or lost its payload. The disabled half-precision code and the illegal codes are run to catch a stale result leaking through. Back-pressure is held for several cycles to catch an output that changes or an operand lost while the consumer stalls.

// File: rtl/rint_pkg.sv
package rint_pkg;
  localparam int unsigned DATA_W = 64;

  localparam logic [1:0] SZ_HALF   = 2'b01;
  localparam logic [1:0] SZ_SINGLE = 2'b10;

  localparam int unsigned H_EXP = 5;
  localparam int unsigned H_MAN = 10;
  localparam int unsigned S_EXP = 8;
  localparam int unsigned S_MAN = 23;

  typedef struct packed {
    logic              undef;
    logic [DATA_W-1:0] data;
  } rint_res_t;
endpackage

// File: rtl/rint_lane.sv
module rint_lane #(
  parameter int unsigned EXP_W = 5,
  parameter int unsigned MAN_W = 10,
  localparam int unsigned W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] a,
  input  logic         dnan_en,
  output logic [W-1:0] y
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int FW   = $clog2(MAN_W + 2);
  localparam logic [MAN_W+1:0] ONE = {{(MAN_W+1){1'b0}}, 1'b1};

  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] mn;
  logic [FW-1:0]    fbits;
  logic [MAN_W+1:0] sig, step, mask, halfv, rem, trunc, sum;
  logic             lsb, up;

  always_comb begin
    sgn   = a[W-1];
    ex    = a[W-2:MAN_W];
    mn    = a[MAN_W-1:0];
    // number of fraction bits that lie below the binary point
    fbits = FW'((BIAS + int'(MAN_W)) - int'(ex));
    sig   = {1'b0, 1'b1, mn};
    step  = ONE << fbits;
    mask  = step - ONE;
    halfv = step >> 1;
    rem   = sig & mask;
    trunc = sig & ~mask;
    lsb   = |(sig & step);
    up    = (rem > halfv) || ((rem == halfv) && lsb);
    sum   = trunc + (up ? step : '0);

    y = a;
    if (ex == {EXP_W{1'b1}}) begin
      if (mn != '0) begin
        if (dnan_en) y = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
        else         y = {sgn, ex, 1'b1, mn[MAN_W-2:0]};
      end
    end else if (ex == '0) begin
      y = {sgn, {(W-1){1'b0}}};
    end else if (int'(ex) >= BIAS + int'(MAN_W)) begin
      y = a;
    end else if (int'(ex) < BIAS - 1) begin
      y = {sgn, {(W-1){1'b0}}};
    end else if (int'(ex) == BIAS - 1) begin
      if (mn == '0) y = {sgn, {(W-1){1'b0}}};
      else          y = {sgn, EXP_W'(BIAS), {MAN_W{1'b0}}};
    end else if (sum[MAN_W+1]) begin
      y = {sgn, ex + 1'b1, {MAN_W{1'b0}}};
    end else begin
      y = {sgn, ex, sum[MAN_W-1:0]};
    end
  end
endmodule

// File: rtl/rint_vec.sv
module rint_vec #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned EXP_W  = 5,
  parameter int unsigned MAN_W  = 10
) (
  input  logic [DATA_W-1:0] a,
  input  logic              dnan_en,
  output logic [DATA_W-1:0] y
);
  localparam int unsigned LANE_W = 1 + EXP_W + MAN_W;
  localparam int unsigned LANES  = DATA_W / LANE_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    rint_lane #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_lane (
      .a       (a[i*LANE_W +: LANE_W]),
      .dnan_en (dnan_en),
      .y       (y[i*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/rint_packed.sv
module rint_packed
  import rint_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_en,
  input  logic              dnan_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_size,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_undef
);
  logic [DATA_W-1:0] half_y, single_y;
  rint_res_t         nxt;
  logic              sel_half, sel_single, take;

  rint_vec #(.DATA_W(DATA_W), .EXP_W(H_EXP), .MAN_W(H_MAN)) u_half (
    .a(in_data), .dnan_en(dnan_en), .y(half_y)
  );
  rint_vec #(.DATA_W(DATA_W), .EXP_W(S_EXP), .MAN_W(S_MAN)) u_single (
    .a(in_data), .dnan_en(dnan_en), .y(single_y)
  );

  always_comb begin
    sel_half   = (in_size == SZ_HALF) && half_en;
    sel_single = (in_size == SZ_SINGLE);
    nxt.undef  = !(sel_half || sel_single);
    if (sel_half)        nxt.data = half_y;
    else if (sel_single) nxt.data = single_y;
    else                 nxt.data = '0;
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_undef <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take) begin
        out_data  <= nxt.data;
        out_undef <= nxt.undef;
      end
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_undef));

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_undef_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_undef |-> out_data == '0);

  p_inf_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_size == SZ_SINGLE && in_data[30:23] == 8'hFF && in_data[22:0] == '0
    |=> out_data[31:0] == $past(in_data[31:0]));

  p_nan_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_size == SZ_SINGLE && in_data[30:23] == 8'hFF && in_data[22:0] != '0
    |=> out_data[30:22] == 9'h1FF);
endmodule

// File: tb/rint_packed_test.sv
module rint_packed_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  sz;
    logic        he;
    logic        dn;
    logic [63:0] din;
    logic [63:0] dout;
    logic        und;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    // R4 ties and carries, half lanes
    '{4'd4, 2'b01, 1'b1, 1'b0, 64'hB800_4300_4100_3E00, 64'h8000_4400_4000_4000, 1'b0},
    // R5 below one, half lanes
    '{4'd5, 2'b01, 1'b1, 1'b0, 64'h3A00_3400_BA00_3800, 64'h3C00_0000_BC00_0000, 1'b0},
    // R6 integral pass-through and carry into exponent
    '{4'd6, 2'b01, 1'b1, 1'b0, 64'h6400_63FF_4180_3D00, 64'h6400_6400_4200_3C00, 1'b0},
    // R7 infinities, subnormals
    '{4'd7, 2'b01, 1'b1, 1'b0, 64'h7C00_FC00_8001_0001, 64'h7C00_FC00_8000_0000, 1'b0},
    // R8 NaN quieting
    '{4'd8, 2'b01, 1'b1, 1'b0, 64'h7C01_FE00_7D55_3C00, 64'h7E01_FE00_7F55_3C00, 1'b0},
    // R8 default NaN
    '{4'd8, 2'b01, 1'b1, 1'b1, 64'h7C01_FE00_7D55_4100, 64'h7E00_7E00_7E00_4000, 1'b0},
    // R2 single lanes
    '{4'd2, 2'b10, 1'b1, 1'b0, 64'h40600000_40200000, 64'h40800000_40000000, 1'b0},
    // R4 negative tie, R6 large value
    '{4'd4, 2'b10, 1'b1, 1'b0, 64'hBFC00000_4B000000, 64'hC0000000_4B000000, 1'b0},
    // R5 single
    '{4'd5, 2'b10, 1'b1, 1'b0, 64'h3E99999A_BF333333, 64'h00000000_BF800000, 1'b0},
    // R4 single ties
    '{4'd4, 2'b10, 1'b1, 1'b0, 64'h40B00000_40900000, 64'h40C00000_40800000, 1'b0},
    // R8 single quiet
    '{4'd8, 2'b10, 1'b1, 1'b0, 64'hFF800000_7F800001, 64'hFF800000_7FC00001, 1'b0},
    // R8 single default NaN
    '{4'd8, 2'b10, 1'b1, 1'b1, 64'hFFC00005_7F800001, 64'h7FC00000_7FC00000, 1'b0},
    // R3 illegal codes
    '{4'd3, 2'b00, 1'b1, 1'b0, 64'h4100_4100_4100_4100, 64'h0, 1'b1},
    '{4'd3, 2'b11, 1'b1, 1'b0, 64'h4100_4100_4100_4100, 64'h0, 1'b1},
    '{4'd3, 2'b01, 1'b0, 1'b0, 64'h4100_4100_4100_4100, 64'h0, 1'b1},
    // R2 with half disabled
    '{4'd2, 2'b10, 1'b0, 1'b0, 64'h40600000_3F000000, 64'h40800000_00000000, 1'b0},
    // R1 lane layout: same word read as half and as single
    '{4'd1, 2'b01, 1'b1, 1'b0, 64'h4100_4100_4100_4100, 64'h4000_4000_4000_4000, 1'b0},
    '{4'd2, 2'b10, 1'b1, 1'b0, 64'h4100_4100_4100_4100, 64'h41000000_41000000, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        half_en = 1'b1;
  logic        dnan_en = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_size = 2'b01;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic        out_undef;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rint_packed uut (
    .clk(clk), .rst_n(rst_n), .half_en(half_en), .dnan_en(dnan_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_size(in_size), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_undef(out_undef)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    in_valid = 1'b1; in_size = v.sz; half_en = v.he; dnan_en = v.dn; in_data = v.din;
    @(negedge clk);
    in_valid = 1'b0;
    check($sformatf("R%0d valid", v.req), {63'd0, out_valid}, 64'd1);
    check($sformatf("R%0d data", v.req), out_data, v.dout);
    check($sformatf("R%0d undef", v.req), {63'd0, out_undef}, {63'd0, v.und});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    check("R10 out_valid", {63'd0, out_valid}, 64'd0);
    check("R10 in_ready", {63'd0, in_ready}, 64'd1);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R9 back-pressure: first result held, second operand waits
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_size = 2'b10; half_en = 1'b1; dnan_en = 1'b0;
    in_data = 64'h40600000_40200000;
    @(negedge clk);
    in_data = 64'h40B00000_40900000;
    check("R9 stall ready low", {63'd0, in_ready}, 64'd0);
    repeat (3) @(negedge clk);
    check("R9 held valid", {63'd0, out_valid}, 64'd1);
    check("R9 held data", out_data, 64'h40800000_40000000);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 second valid", {63'd0, out_valid}, 64'd1);
    check("R9 second data", out_data, 64'h40C00000_40800000);
    @(negedge clk);
    check("R9 drained", {63'd0, out_valid}, 64'd0);

    // R10 reset clears a held result
    out_ready = 1'b0;
    in_valid = 1'b1; in_data = 64'h0;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R10 cleared valid", {63'd0, out_valid}, 64'd0);
    out_ready = 1'b1;

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule